// File: doc/BRIEF.md
# Zero-Crossing Gated Update Scheduler

This block sits between a serial command register and the switch drivers of a digitally controlled preamplifier. The command register hands it a new gain code, a new value for four general-purpose port outputs, and one scheduling mode bit for each of the two. When a command frame completes, a commit strobe tells this block to act on those values.

In immediate mode a value goes live straight away. In deferred mode the value is parked. It is applied when a window comparator reports that the monitored audio signal is close to zero. If no zero crossing arrives, it is applied when a clock-cycle timeout runs out instead.

The timeout replaces an external RC timer. It is held cleared while a command frame is in flight, and it restarts on every commit. The comparator input is asynchronous and passes through a two-flop synchronizer. A busy flag stays high for as long as any deferred value is waiting.

Top module: `zc_update_sched`

## Requirements
- R1: While rstN is low, gainOut is 0, portOut is 0 and busy is 0, and nothing is pending.
- R2: When a commit is sampled with cmdGainMode = 0, gainOut equals cmdGain after that same clock edge.
- R3: When a commit is sampled with cmdPortMode = 0, portOut equals cmdPort after that same clock edge.
- R4: When a commit is sampled with a mode bit = 1, the matching output keeps its old value and busy is 1 after that edge until the value is applied.
- R5: zcRaw passes through two flops. If zcRaw is high before edge j while an update is pending, the parked value appears after edge j+2 and not before.
- R6: With no zero crossing, a parked value appears TIMEOUT_CYCLES edges after the commit edge. It does not appear one edge earlier.
- R7: The timeout is held cleared from a frame-start strobe until the next commit. A parked value is therefore never applied by timeout during a frame, but it is still applied by a zero crossing.
- R8: A new commit while an update is pending replaces the parked value with the newest one and restarts the timeout.
- R9: When one field is immediate and the other is deferred, the immediate field changes at the commit and busy reflects only the deferred field.
- R10: busy falls on the same edge at which the last parked value is applied.
- R11: A zero crossing with nothing pending leaves gainOut, portOut and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdGain | input | GAIN_W | Gain code from the command register |
| cmdPort | input | PORT_W | Port value from the command register |
| cmdGainMode | input | 1 | 0 = apply gain at commit, 1 = defer to zero crossing |
| cmdPortMode | input | 1 | 0 = apply ports at commit, 1 = defer to zero crossing |
| commitStb | input | 1 | One-cycle strobe at the end of a command frame |
| frameStartStb | input | 1 | One-cycle strobe at the start of a command frame |
| zcRaw | input | 1 | Asynchronous near-zero indication from the window comparator |
| gainOut | output | GAIN_W | Live gain code |
| portOut | output | PORT_W | Live port outputs |
| busy | output | 1 | High while any deferred update waits |

## Verification
Several properties are checked on every cycle:
- the timeout counter never passes its limit;
- the counter is zero after any cycle spent inside a frame;
- an expiry never happens during a frame;
- each output moves only on an apply strobe, and a deferred apply delivers exactly the parked value.

Other behaviour can only be shown by the bench scenarios, because it depends on absolute cycle counts across the synchronizer and the timeout:
- the exact edge at which a parked value lands after a zero crossing or after expiry;
- the restart of the timeout on replacement;
- the hold of the timeout across a long frame;
- the split busy behaviour under mixed modes.

// File: rtl/zc_sched_pkg.sv
package zc_sched_pkg;

  // Apply strobes from the control module to the datapath.
  typedef struct packed {
    logic captureCmd;   // park the command values on a commit
    logic gainFromCmd;  // load gain straight from the command
    logic gainFromHold; // load gain from the parked value
    logic portFromCmd;  // load ports straight from the command
    logic portFromHold; // load ports from the parked value
  } upd_strobes_t;

endpackage

// File: rtl/zc_sched_ctrl.sv
module zc_sched_ctrl
  import zc_sched_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5_500_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         commitStb,
  input  logic         frameStartStb,
  input  logic         gainModeIn,
  input  logic         portModeIn,
  input  logic         zcRaw,
  output upd_strobes_t strobes,
  output logic         busy
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] zcPipe;
  logic                   zcSync;
  logic                   frameActive;
  logic                   gainPend;
  logic                   portPend;
  logic [CNT_W-1:0]       cnt;
  logic                   holdCnt;
  logic                   expire;
  logic                   fire;

  // Synchronizer for the comparator input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zcPipe <= '0;
    else       zcPipe <= {zcPipe[SYNC_STAGES-2:0], zcRaw};
  end
  assign zcSync = zcPipe[SYNC_STAGES-1];

  // Frame-in-flight flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              frameActive <= 1'b0;
    else if (commitStb)     frameActive <= 1'b0;
    else if (frameStartStb) frameActive <= 1'b1;
  end

  // Timeout counter
  assign holdCnt = frameActive | frameStartStb | commitStb | ~(gainPend | portPend);
  assign expire  = ~holdCnt & (cnt == CNT_LAST);
  assign fire    = zcSync | expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (holdCnt)       cnt <= '0;
    else if (cnt != CNT_LIM) cnt <= cnt + 1'b1;
  end

  // Pending flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainPend <= 1'b0;
      portPend <= 1'b0;
    end else if (commitStb) begin
      gainPend <= gainModeIn;
      portPend <= portModeIn;
    end else if (fire) begin
      gainPend <= 1'b0;
      portPend <= 1'b0;
    end
  end

  always_comb begin
    strobes              = '0;
    strobes.captureCmd   = commitStb;
    strobes.gainFromCmd  = commitStb & ~gainModeIn;
    strobes.portFromCmd  = commitStb & ~portModeIn;
    strobes.gainFromHold = ~commitStb & gainPend & fire;
    strobes.portFromHold = ~commitStb & portPend & fire;
  end

  assign busy = gainPend | portPend;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LIM);

  // R7
  frame_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameActive |=> (cnt == '0));

  // R7
  no_expire_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameActive |-> !expire);

  // R2
  gain_src_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.gainFromCmd, strobes.gainFromHold}));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fire && !commitStb) |=> !busy);

endmodule

// File: rtl/zc_sched_data.sv
module zc_sched_data
  import zc_sched_pkg::*;
#(
  parameter int GAIN_W = 5,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  upd_strobes_t      strobes,
  input  logic [GAIN_W-1:0] cmdGain,
  input  logic [PORT_W-1:0] cmdPort,
  output logic [GAIN_W-1:0] gainOut,
  output logic [PORT_W-1:0] portOut
);

  logic [GAIN_W-1:0] gainHold;
  logic [PORT_W-1:0] portHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainHold <= '0;
      portHold <= '0;
    end else if (strobes.captureCmd) begin
      gainHold <= cmdGain;
      portHold <= cmdPort;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     gainOut <= '0;
    else if (strobes.gainFromCmd)  gainOut <= cmdGain;
    else if (strobes.gainFromHold) gainOut <= gainHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     portOut <= '0;
    else if (strobes.portFromCmd)  portOut <= cmdPort;
    else if (strobes.portFromHold) portOut <= portHold;
  end

  // R4
  gain_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.gainFromCmd || strobes.gainFromHold) |=> $stable(gainOut));

  // R4
  port_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.portFromCmd || strobes.portFromHold) |=> $stable(portOut));

  // R5
  gain_hold_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gainFromHold |=> (gainOut == $past(gainHold)));

  // R5
  port_hold_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.portFromHold |=> (portOut == $past(portHold)));

endmodule

// File: rtl/zc_update_sched.sv
module zc_update_sched #(
  parameter int GAIN_W         = 5,
  parameter int PORT_W         = 4,
  parameter int TIMEOUT_CYCLES = 5_500_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GAIN_W-1:0] cmdGain,
  input  logic [PORT_W-1:0] cmdPort,
  input  logic              cmdGainMode,
  input  logic              cmdPortMode,
  input  logic              commitStb,
  input  logic              frameStartStb,
  input  logic              zcRaw,
  output logic [GAIN_W-1:0] gainOut,
  output logic [PORT_W-1:0] portOut,
  output logic              busy
);

  zc_sched_pkg::upd_strobes_t strobes;

  zc_sched_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES   (2)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .commitStb    (commitStb),
    .frameStartStb(frameStartStb),
    .gainModeIn   (cmdGainMode),
    .portModeIn   (cmdPortMode),
    .zcRaw        (zcRaw),
    .strobes      (strobes),
    .busy         (busy)
  );

  zc_sched_data #(
    .GAIN_W(GAIN_W),
    .PORT_W(PORT_W)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cmdGain(cmdGain),
    .cmdPort(cmdPort),
    .gainOut(gainOut),
    .portOut(portOut)
  );

endmodule

// File: tb/tb_zc_update_sched.sv
`timescale 1ns/1ps
module tb_zc_update_sched;

  localparam int LIM = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] cmdGain = '0;
  logic [3:0] cmdPort = '0;
  logic       cmdGainMode = 1'b0;
  logic       cmdPortMode = 1'b0;
  logic       commitStb = 1'b0;
  logic       frameStartStb = 1'b0;
  logic       zcRaw = 1'b0;
  logic [4:0] gainOut;
  logic [3:0] portOut;
  logic       busy;

  int  cyc = 0;
  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  typedef struct {
    int         cyc;
    string      tag;
    logic [4:0] g;
    logic [3:0] p;
    logic       b;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zc_update_sched #(.GAIN_W(5), .PORT_W(4), .TIMEOUT_CYCLES(LIM)) dut (
    .clk(clk), .rstN(rstN), .cmdGain(cmdGain), .cmdPort(cmdPort),
    .cmdGainMode(cmdGainMode), .cmdPortMode(cmdPortMode),
    .commitStb(commitStb), .frameStartStb(frameStartStb), .zcRaw(zcRaw),
    .gainOut(gainOut), .portOut(portOut), .busy(busy)
  );

  // Monitor: pops expectations whose cycle has come
  always @(negedge clk) begin
    exp_t e;
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      nChecks++;
      if (e.cyc < cyc || gainOut !== e.g || portOut !== e.p || busy !== e.b) begin
        nFail++;
        $display("FAIL %s cyc %0d: got g=%0d p=%h b=%b, expected g=%0d p=%h b=%b (at cyc %0d)",
                 e.tag, cyc, gainOut, portOut, busy, e.g, e.p, e.b, e.cyc);
      end
    end
  end

  task automatic expect_at(input int c, input string tag,
                           input logic [4:0] g, input logic [3:0] p, input logic b);
    exp_t e;
    e.cyc = c; e.tag = tag; e.g = g; e.p = p; e.b = b;
    q.push_back(e);
  endtask

  task automatic start_frame();
    @(negedge clk); frameStartStb = 1'b1;
    @(negedge clk); frameStartStb = 1'b0;
  endtask

  task automatic do_commit(input logic [4:0] g, input logic [3:0] p,
                           input logic gm, input logic pm, output int cc);
    @(negedge clk);
    cmdGain = g; cmdPort = p; cmdGainMode = gm; cmdPortMode = pm;
    commitStb = 1'b1; cc = cyc;
    @(negedge clk); commitStb = 1'b0;
  endtask

  task automatic full_commit(input logic [4:0] g, input logic [3:0] p,
                             input logic gm, input logic pm, output int cc);
    start_frame();
    do_commit(g, p, gm, pm, cc);
  endtask

  task automatic raise_zc(output int zc);
    @(negedge clk); zcRaw = 1'b1; zc = cyc;
  endtask

  task automatic drop_zc();
    @(negedge clk); zcRaw = 1'b0;
  endtask

  task automatic wait_drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int c;
    int c2;
    int z;

    // R1: reset state
    repeat (3) @(negedge clk);
    expect_at(cyc, "R1 in reset", 5'd0, 4'h0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    expect_at(cyc + 1, "R1 after release", 5'd0, 4'h0, 1'b0);
    wait_drain();

    // R2, R3: immediate updates
    full_commit(5'd7, 4'h5, 1'b0, 1'b0, c);
    expect_at(c + 1, "R2 R3 immediate", 5'd7, 4'h5, 1'b0);
    wait_drain();

    // R11: zero crossing with nothing pending
    raise_zc(z);
    expect_at(z + 4, "R11 zc idle", 5'd7, 4'h5, 1'b0);
    wait_drain();
    drop_zc();
    repeat (3) @(negedge clk);

    // R4, R5, R10: deferred both, applied by zero crossing
    full_commit(5'd20, 4'hA, 1'b1, 1'b1, c);
    expect_at(c + 1, "R4 deferred parked", 5'd7, 4'h5, 1'b1);
    expect_at(c + 10, "R4 still parked", 5'd7, 4'h5, 1'b1);
    repeat (12) @(negedge clk);
    raise_zc(z);
    expect_at(z + 2, "R5 not before sync", 5'd7, 4'h5, 1'b1);
    expect_at(z + 3, "R5 R10 zc apply", 5'd20, 4'hA, 1'b0);
    wait_drain();
    drop_zc();
    repeat (3) @(negedge clk);

    // R6, R9: gain deferred by timeout, ports immediate
    full_commit(5'd3, 4'h6, 1'b1, 1'b0, c);
    expect_at(c + 1, "R9 mixed modes", 5'd20, 4'h6, 1'b1);
    expect_at(c + LIM, "R6 one before expiry", 5'd20, 4'h6, 1'b1);
    expect_at(c + 1 + LIM, "R6 timeout apply", 5'd3, 4'h6, 1'b0);
    wait_drain();

    // R8: replacement restarts the timeout
    full_commit(5'd9, 4'h6, 1'b1, 1'b0, c);
    expect_at(c + 1, "R8 first parked", 5'd3, 4'h6, 1'b1);
    repeat (20) @(negedge clk);
    full_commit(5'd12, 4'h6, 1'b1, 1'b0, c2);
    expect_at(c + 1 + LIM, "R8 old timeout gone", 5'd3, 4'h6, 1'b1);
    expect_at(c2 + LIM, "R8 restarted", 5'd3, 4'h6, 1'b1);
    expect_at(c2 + 1 + LIM, "R8 newest applied", 5'd12, 4'h6, 1'b0);
    wait_drain();

    // R7: frame in flight holds the timeout; zc still applies
    full_commit(5'd12, 4'h3, 1'b0, 1'b1, c);
    expect_at(c + 1, "R9 port deferred", 5'd12, 4'h6, 1'b1);
    repeat (4) @(negedge clk);
    start_frame();
    repeat (LIM + 20) @(negedge clk);
    expect_at(cyc + 1, "R7 held in frame", 5'd12, 4'h6, 1'b1);
    wait_drain();
    raise_zc(z);
    expect_at(z + 3, "R7 zc in frame", 5'd12, 4'h3, 1'b0);
    wait_drain();
    drop_zc();
    do_commit(5'd12, 4'h3, 1'b0, 1'b0, c);
    expect_at(c + 1, "R2 close frame", 5'd12, 4'h3, 1'b0);
    wait_drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, got hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule